// File: doc/BRIEF.md
# I/O Window Address Translator

This block sits between a CPU's load/store port and a byte-addressed I/O port space. A CPU access that lands in an 8 MB window starting at 0x80000000 becomes one I/O-side cycle carrying a 16-bit port address, the access size, the write data and a one-cycle read or write strobe. Two address mappings are supported, and a mode input that comes from the board control register selects between them. The contiguous mapping takes the low 16 bits of the window offset. The spread mapping keeps offset bits [4:0] and moves page bits [22:12] down by seven places, so each group of 32 ports sits on its own 4 KB page.

For a big-endian CPU the data lanes are reordered on the way out and on the way back. A half-word swaps its two low bytes, a word reverses all four bytes, and a byte passes unchanged. A second, 4-byte region at 0xBFFFFFF0 is the interrupt-acknowledge location. A read at offset 0 raises an acknowledge request to the interrupt controller and returns its vector, with the same lane ordering applied. Reads at other offsets return zero, and writes have no effect. Any other address is not forwarded and raises a one-cycle decode-miss flag.

A controller state machine runs each access through these states:
- ST_IDLE accepts a request. Its transitions are GO_IO (window hit), GO_IACK (acknowledge-region hit) and GO_MISS (no region).
- ST_IO, ST_IACK and ST_MISS each last one cycle and then take the transition FINISH to ST_DONE.
- ST_DONE returns the response and then takes the transition RELEASE back to ST_IDLE.

Top module: `iowin_xlate`

## Requirements
- R1: While reset is held and after its release, with no request pending, all strobes, the acknowledge request, the decode-miss flag, cpu_ack and cpu_rdata are 0.
- R2: A request whose address lies in 0x80000000..0x807FFFFF gives exactly one io_rd or io_wr pulse in the cycle after the request is sampled, with io_size equal to cpu_size. cpu_ack pulses in the following cycle. When cpu_rd and cpu_wr are both high, the request is a read.
- R3: With map_spread = 0, io_addr is cpu_addr[15:0].
- R4: With map_spread = 1, io_addr is {cpu_addr[22:12], cpu_addr[4:0]}, so that bit 12 of the CPU address becomes bit 5 of the port address.
- R5: Size codes are 0 = byte, 1 = half-word and 2 = word; code 3 is never swapped. With cpu_big_endian = 1, a half-word exchanges bits [7:0] and [15:8] and leaves bits [31:16] unchanged, and a word reverses its four bytes. This applies to io_wdata for writes and to the value returned on cpu_rdata for reads. Byte accesses, and all accesses with cpu_big_endian = 0, pass unchanged.
- R6: A read whose address is 0xBFFFFFF0 pulses iack_req for one cycle, with no I/O strobe, and returns intc_vector on cpu_rdata. Reads at 0xBFFFFFF1..0xBFFFFFF3 return 0 and do not pulse iack_req.
- R7: A write to 0xBFFFFFF0..0xBFFFFFF3 produces no I/O strobe and no iack_req, and is still acknowledged with cpu_rdata = 0.
- R8: The acknowledge vector returned on cpu_rdata follows the swap rule of R5.
- R9: A request outside both regions produces no strobe and no iack_req. decode_miss pulses for one cycle, then cpu_ack pulses with cpu_rdata = 0.
- R10: Strobes that arrive while an access is in progress are ignored. Each accepted access produces exactly one cpu_ack and at most one I/O strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_spread | input | 1 | Mapping mode from board control: 0 contiguous, 1 spread |
| cpu_big_endian | input | 1 | CPU is big-endian; enables lane swapping |
| cpu_addr | input | 32 | CPU physical address |
| cpu_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rd | input | 1 | Read request strobe |
| cpu_wr | input | 1 | Write request strobe |
| cpu_rdata | output | 32 | Read data, valid while cpu_ack is high |
| cpu_ack | output | 1 | Access complete, one cycle |
| io_addr | output | 16 | Translated port address |
| io_size | output | 2 | Access size forwarded to the I/O side |
| io_wdata | output | 32 | Lane-ordered write data |
| io_rd | output | 1 | I/O read strobe, one cycle |
| io_wr | output | 1 | I/O write strobe, one cycle |
| io_rdata | input | 32 | I/O read data, valid while io_rd is high |
| intc_vector | input | 32 | Vector from the interrupt controller, valid while iack_req is high |
| iack_req | output | 1 | Interrupt acknowledge request, one cycle |
| decode_miss | output | 1 | Address hit neither region, one cycle |

## Verification
The assertions check on every cycle that the I/O strobes, iack_req and decode_miss are never active together and each lasts only one cycle, and that every such action is followed by exactly one cpu_ack. Only the bench scenarios can show that the translated port address, the lane ordering for each size and endianness, and the returned vector or zero value are correct. The same holds for requests made during a busy access, which must leave no trace at the ports.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IO,
        ST_IACK,
        ST_MISS,
        ST_DONE
    } xl_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xl_size_e;

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter int          WIN_BITS   = 23,
    parameter logic [31:0] IACK_BASE  = 32'hBFFF_FFF0,
    parameter int          IACK_BITS  = 2,
    parameter int          PORT_BITS  = 16,
    parameter int          GROUP_BITS = 5,
    parameter int          FOLD       = 7
) (
    input  logic [31:0]          addr,
    input  logic                 spread,
    output logic                 hit_win,
    output logic                 hit_iack,
    output logic                 iack_first,
    output logic [PORT_BITS-1:0] port
);
    localparam int          PAGE_LSB = GROUP_BITS + FOLD;
    localparam logic [31:0] GRP_MASK = (32'd1 << GROUP_BITS) - 32'd1;

    logic [31:0] off32;
    logic [31:0] spread32;

    assign hit_win    = (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
    assign hit_iack   = (addr[31:IACK_BITS] == IACK_BASE[31:IACK_BITS]);
    assign iack_first = (addr[3:0] == 4'h0);

    assign off32    = 32'(addr[WIN_BITS-1:0]);
    assign spread32 = ((off32 >> PAGE_LSB) << GROUP_BITS) | (off32 & GRP_MASK);

    generate
        if (PORT_BITS <= WIN_BITS) begin : g_port
            assign port = spread ? spread32[PORT_BITS-1:0] : off32[PORT_BITS-1:0];
        end else begin : g_port_wide
            assign port = spread ? spread32[PORT_BITS-1:0] : off32[PORT_BITS-1:0];
        end
    endgenerate
endmodule

// File: rtl/iowin_swap.sv
module iowin_swap
    import iowin_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    input  logic              big_endian,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] rev_all;
    logic [DATA_W-1:0] rev_half;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            assign rev_all[8*i +: 8] = din[8*(LANES-1-i) +: 8];
            if (i < 2) begin : g_low
                assign rev_half[8*i +: 8] = din[8*(1-i) +: 8];
            end else begin : g_high
                assign rev_half[8*i +: 8] = din[8*i +: 8];
            end
        end
    endgenerate

    always_comb begin
        dout = din;
        if (big_endian) begin
            unique case (xl_size_e'(size))
                SZ_HALF: dout = rev_half;
                SZ_WORD: dout = rev_all;
                default: dout = din;
            endcase
        end
    end
endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
    import iowin_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
    parameter int          WIN_BITS   = 23,
    parameter logic [31:0] IACK_BASE  = 32'hBFFF_FFF0,
    parameter int          IACK_BITS  = 2,
    parameter int          PORT_BITS  = 16,
    parameter int          GROUP_BITS = 5,
    parameter int          FOLD       = 7,
    parameter int          DATA_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_spread,
    input  logic                 cpu_big_endian,
    input  logic [31:0]          cpu_addr,
    input  logic [1:0]           cpu_size,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 cpu_ack,
    output logic [PORT_BITS-1:0] io_addr,
    output logic [1:0]           io_size,
    output logic [DATA_W-1:0]    io_wdata,
    output logic                 io_rd,
    output logic                 io_wr,
    input  logic [DATA_W-1:0]    io_rdata,
    input  logic [DATA_W-1:0]    intc_vector,
    output logic                 iack_req,
    output logic                 decode_miss
);
    xl_state_e state_q, state_d;

    logic                 req;
    logic                 hit_win, hit_iack, iack_first;
    logic [PORT_BITS-1:0] port_d;
    logic [DATA_W-1:0]    wdata_sw;
    logic [DATA_W-1:0]    rsrc, rsrc_sw;

    logic                 is_rd_q, first_q, be_q;
    logic [1:0]           size_q;
    logic [PORT_BITS-1:0] port_q;
    logic [DATA_W-1:0]    wdata_q, rdata_q;

    assign req = cpu_rd | cpu_wr;

    iowin_decode #(
        .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS), .IACK_BASE(IACK_BASE),
        .IACK_BITS(IACK_BITS), .PORT_BITS(PORT_BITS),
        .GROUP_BITS(GROUP_BITS), .FOLD(FOLD)
    ) u_dec (
        .addr(cpu_addr), .spread(map_spread), .hit_win(hit_win),
        .hit_iack(hit_iack), .iack_first(iack_first), .port(port_d)
    );

    iowin_swap #(.DATA_W(DATA_W)) u_wswap (
        .din(cpu_wdata), .size(cpu_size), .big_endian(cpu_big_endian),
        .dout(wdata_sw)
    );

    assign rsrc = (state_q == ST_IO) ? io_rdata : intc_vector;

    iowin_swap #(.DATA_W(DATA_W)) u_rswap (
        .din(rsrc), .size(size_q), .big_endian(be_q), .dout(rsrc_sw)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: GO_IO / GO_IACK / GO_MISS, FINISH, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (hit_win)       state_d = ST_IO;
                    else if (hit_iack) state_d = ST_IACK;
                    else               state_d = ST_MISS;
                end
            end
            ST_IO, ST_IACK, ST_MISS: state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_rd_q <= 1'b0;
            first_q <= 1'b0;
            be_q    <= 1'b0;
            size_q  <= 2'd0;
            port_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        is_rd_q <= cpu_rd;
                        first_q <= iack_first;
                        be_q    <= cpu_big_endian;
                        size_q  <= cpu_size;
                        port_q  <= port_d;
                        wdata_q <= wdata_sw;
                    end
                end
                ST_IO:   rdata_q <= is_rd_q ? rsrc_sw : '0;
                ST_IACK: rdata_q <= (is_rd_q && first_q) ? rsrc_sw : '0;
                ST_MISS: rdata_q <= '0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        io_rd       = 1'b0;
        io_wr       = 1'b0;
        iack_req    = 1'b0;
        decode_miss = 1'b0;
        cpu_ack     = 1'b0;
        cpu_rdata   = '0;
        io_addr     = '0;
        io_size     = 2'd0;
        io_wdata    = '0;
        unique case (state_q)
            ST_IO: begin
                io_rd    = is_rd_q;
                io_wr    = !is_rd_q;
                io_addr  = port_q;
                io_size  = size_q;
                io_wdata = is_rd_q ? '0 : wdata_q;
            end
            ST_IACK: iack_req    = is_rd_q && first_q;
            ST_MISS: decode_miss = 1'b1;
            ST_DONE: begin
                cpu_ack   = 1'b1;
                cpu_rdata = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/iowin_xlate_chk.sv
module iowin_xlate_chk (
    input logic clk,
    input logic rst_n,
    input logic io_rd,
    input logic io_wr,
    input logic iack_req,
    input logic decode_miss,
    input logic cpu_ack
);
    logic act;
    assign act = io_rd | io_wr | iack_req | decode_miss;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr, iack_req, decode_miss, cpu_ack}));  // R2
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> cpu_ack);  // R2
    AST_IO_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd | io_wr) |=> !(io_rd | io_wr));  // R10
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);  // R10
    AST_IACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        iack_req |=> !iack_req);  // R6
    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        decode_miss |=> !decode_miss);  // R9
endmodule

bind iowin_xlate iowin_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
    .iack_req(iack_req), .decode_miss(decode_miss), .cpu_ack(cpu_ack)
);

// File: tb/iowin_xlate_test.sv
module iowin_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_spread = 1'b0, cpu_big_endian = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, intc_vector = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [31:0] cpu_rdata, io_wdata, io_rdata;
    logic        cpu_ack, io_rd, io_wr, iack_req, decode_miss;
    logic [15:0] io_addr;
    logic [1:0]  io_size;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // device model: read data depends on port address
    assign io_rdata = {io_addr ^ 16'hA5C3, io_addr};

    iowin_xlate uut (.*);

    function automatic logic [31:0] swap_ref(logic [31:0] d, logic [1:0] sz, logic be);
        if (!be) return d;
        if (sz == 2'd1) return {d[31:16], d[7:0], d[15:8]};
        if (sz == 2'd2) return {d[7:0], d[15:8], d[23:16], d[31:24]};
        return d;
    endfunction

    function automatic logic [15:0] port_ref(logic [31:0] a, logic sp);
        if (sp) return {a[22:12], a[4:0]};
        return a[15:0];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access: request sampled at E0, action after E0, ack after E1
    task automatic access(logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                          bit rd, bit sp, bit be, logic [31:0] vec);
        bit in_win  = (a[31:23] == 9'h100);
        bit in_iack = (a[31:2] == 30'h2FFF_FFFC);
        logic [31:0] exp_rd;
        @(negedge clk);
        cpu_addr = a; cpu_size = sz; cpu_wdata = wd; cpu_rd = rd; cpu_wr = !rd;
        map_spread = sp; cpu_big_endian = be; intc_vector = vec;
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0;
        if (in_win) begin
            chk(io_rd == rd && io_wr == !rd, "R2 strobe", {io_rd, io_wr}, {rd, !rd});
            chk(io_size == sz, "R2 size", io_size, sz);
            chk(io_addr == port_ref(a, sp), sp ? "R4 port" : "R3 port", io_addr, port_ref(a, sp));
            if (!rd) chk(io_wdata == swap_ref(wd, sz, be), "R5 wdata", io_wdata, swap_ref(wd, sz, be));
            exp_rd = rd ? swap_ref({port_ref(a, sp) ^ 16'hA5C3, port_ref(a, sp)}, sz, be) : 32'h0;
        end else if (in_iack) begin
            chk(!io_rd && !io_wr, rd ? "R6 no strobe" : "R7 no strobe", {io_rd, io_wr}, 0);
            chk(iack_req == (rd && a[3:0] == 0), rd ? "R6 iack_req" : "R7 iack_req",
                iack_req, (rd && a[3:0] == 0));
            exp_rd = (rd && a[3:0] == 0) ? swap_ref(vec, sz, be) : 32'h0;
        end else begin
            chk(decode_miss && !io_rd && !io_wr && !iack_req, "R9 miss",
                {decode_miss, io_rd, io_wr, iack_req}, 4'b1000);
            exp_rd = 0;
        end
        @(negedge clk);
        chk(cpu_ack == 1'b1, "R2 ack", cpu_ack, 1);
        chk(cpu_rdata == exp_rd, in_iack ? "R8 rdata" : "R5 rdata", cpu_rdata, exp_rd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        chk({io_rd, io_wr, iack_req, decode_miss, cpu_ack} == 0 && cpu_rdata == 0,
            "R1 in reset", {io_rd, io_wr, iack_req, decode_miss, cpu_ack}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({io_rd, io_wr, iack_req, decode_miss, cpu_ack} == 0, "R1 idle",
            {io_rd, io_wr, iack_req, decode_miss, cpu_ack}, 0);

        // directed corners
        access(32'h8000_03F8, 2'd0, 32'h0000_0055, 0, 0, 1, 0);      // R3 byte no swap
        access(32'h8001_F01F, 2'd1, 32'hDEAD_BEEF, 0, 1, 1, 0);      // R4 R5 half
        access(32'h807F_F000, 2'd2, 32'h1122_3344, 0, 1, 1, 0);      // R4 top page, word
        access(32'h8000_1000, 2'd2, 0, 1, 1, 1, 0);                  // R4 bit 12 -> bit 5
        access(32'h8000_0092, 2'd2, 32'h1122_3344, 0, 0, 0, 0);      // R5 little-endian
        access(32'h8000_0800, 2'd3, 32'hAABB_CCDD, 0, 0, 1, 0);      // R5 reserved size
        access(32'hBFFF_FFF0, 2'd2, 0, 1, 0, 1, 32'h0000_0009);      // R6 R8
        access(32'hBFFF_FFF0, 2'd1, 0, 1, 0, 0, 32'h0000_1234);      // R6 LE
        access(32'hBFFF_FFF2, 2'd0, 0, 1, 0, 0, 32'h0000_00FF);      // R6 other offset
        access(32'hBFFF_FFF0, 2'd2, 32'hFFFF_FFFF, 0, 0, 0, 32'h7);  // R7
        access(32'h8080_0000, 2'd0, 0, 1, 0, 0, 0);                  // R9 above window
        access(32'h7FFF_FFFF, 2'd0, 0, 0, 0, 0, 0);                  // R9 below window
        access(32'hBFFF_FFF4, 2'd0, 0, 1, 0, 0, 32'h1);              // R9 past iack

        // R10: strobes during a busy access are ignored
        @(negedge clk);
        cpu_addr = 32'h8000_0100; cpu_size = 0; cpu_rd = 1; map_spread = 0;
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 1; cpu_addr = 32'h8000_0200;
        chk(io_rd == 1, "R10 first strobe", io_rd, 1);
        @(negedge clk);
        chk(cpu_ack == 1 && !io_wr, "R10 ack while busy", {cpu_ack, io_wr}, 2'b10);
        @(negedge clk);
        cpu_wr = 0;
        chk(!io_rd && !io_wr && !cpu_ack, "R10 ignored", {io_rd, io_wr, cpu_ack}, 0);
        @(negedge clk);
        chk(!io_rd && !io_wr && !cpu_ack, "R10 no late strobe", {io_rd, io_wr, cpu_ack}, 0);

        // R2: both strobes -> read
        @(negedge clk);
        cpu_addr = 32'h8000_0040; cpu_size = 0; cpu_rd = 1; cpu_wr = 1;
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0;
        chk(io_rd && !io_wr, "R2 read priority", {io_rd, io_wr}, 2'b10);
        @(negedge clk);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            int kind = $urandom % 4;
            case (kind)
                0, 1: a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
                2:    a = 32'hBFFF_FFF0 | ($urandom % 4);
                default: a = ($urandom % 2) ? ($urandom & 32'h7FFF_FFFF) : 32'hC000_0000 | $urandom;
            endcase
            access(a, 2'($urandom % 4), $urandom, 1'($urandom), 1'($urandom),
                   1'($urandom), $urandom);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule